// File: doc/BRIEF.md
# Channel-Gain Scan Sequencer

The sequencer works through a programmable list of sample slots and runs a multi-channel acquisition front end with no software step per sample. Each slot names an analog input channel and, unless per-channel gain mode is on, an amplifier gain code. For each slot the block drives the multiplexer address and the gain code. It waits a settling time taken from a table indexed by that gain code, then gives a one-cycle start-of-conversion strobe. When the converter signals done, the block emits the sample on a valid/ready stream, tagged with the channel and the slot index.

Software loads the slot list, the settling table and the per-channel gain registers through a plain write port while the block is idle. A start pulse runs the list from slot 0 up to a programmable last slot. Samples are paced by an external trigger pulse or by an internal period timer. In single mode the block stops after the last slot and raises a done flag. In continuous mode it wraps to slot 0 until a stop request ends the scan at a slot boundary.

Output back-pressure rule: once `out_valid` is high, the sample, channel and index stay fixed until a cycle with `out_ready` high. The sequencer does not move to the next slot until that handshake has completed.

Top module: `scan_seq`

## Requirements
- R1: A list write (`wr_sel`=0) stores the channel in `wr_data[4:0]` and the gain code in `wr_data[7:5]` at slot `wr_addr`. When a slot is processed, `mux_addr` takes its channel and holds it through the conversion.
- R2: Channel-gain writes use `wr_sel`=2, with the channel in `wr_addr[4:0]` and the gain in `wr_data[2:0]`. When `gain_mode` is high at start, `pga_gain` takes the stored gain of the slot's channel and the slot's own gain bits are ignored. Otherwise `pga_gain` takes the slot's gain bits.
- R3: Settling-table writes use `wr_sel`=2'd1, with the gain in `wr_addr[2:0]` and the count in `wr_data`. If `mux_addr`/`pga_gain` update at clock edge k and the count for the gain is N, `conv_start` is high in the cycle after edge k+N. For N=0 this is the cycle right after the update.
- R4: `conv_start` is high for exactly one cycle per processed slot.
- R5: The first sampled `conv_done` after the strobe captures `conv_data`. One cycle later `out_valid` rises, with `out_chan` equal to the slot channel and `out_index` equal to the slot index.
- R6: If `conv_done` is not seen within 64 cycles after the strobe cycle, `timeout_err` is set, no sample is emitted and the scan advances. The flag is sticky until the next start.
- R7: While `out_valid` is high and `out_ready` low, all output fields hold and the scan does not advance.
- R8: A start pulse while idle raises `busy`, clears the sticky flags and begins at slot 0. In single mode, the handshake (or timeout) of slot `last_idx` drops `busy` and sets `scan_done`. A start while busy has no effect.
- R9: In continuous mode slot `last_idx` is followed by slot 0. A `stop_req` pulse makes the block go idle at the next slot boundary or while waiting for a trigger.
- R10: Each slot waits for a pacing tick. The tick is `ext_trig` when `use_timer` is low. Otherwise it is an internal tick every `timer_period` cycles counted from the start (period 0 acts as 1).
- R11: A pacing tick while busy and not waiting for a tick sets the sticky `overrun` flag and is otherwise ignored.
- R12: Writes of any kind while `busy` is high are ignored.
- R13: After reset all outputs are low, and the list, table and gain registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 list, 1 settling table, 2 channel gain |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| start | input | 1 | Begin a scan at slot 0 |
| stop_req | input | 1 | End the scan at the next slot boundary |
| cont_mode | input | 1 | 1 = wrap continuously, 0 = single pass (latched at start) |
| gain_mode | input | 1 | 1 = per-channel gain registers (latched at start) |
| last_idx | input | 8 | Index of the last slot (latched at start) |
| use_timer | input | 1 | 1 = internal timer paces samples |
| timer_period | input | 16 | Timer period in cycles |
| ext_trig | input | 1 | External pacing pulse |
| mux_addr | output | 5 | Multiplexer channel address |
| pga_gain | output | 3 | Amplifier gain code |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_done | input | 1 | Conversion complete |
| conv_data | input | 16 | Conversion result |
| out_valid | output | 1 | Sample stream valid |
| out_ready | input | 1 | Sample stream ready |
| out_data | output | 16 | Sample value |
| out_chan | output | 5 | Channel of the sample |
| out_index | output | 8 | Slot index of the sample |
| busy | output | 1 | Scan running; writes are ignored |
| scan_done | output | 1 | Single scan finished (sticky) |
| overrun | output | 1 | Tick arrived during a sample (sticky) |
| timeout_err | output | 1 | Converter did not answer (sticky) |

## Verification
The main path is run with slots whose gains map to settling counts of zero, one and several cycles. This separates the immediate-strobe case from the counted wait and catches off-by-one settling. The slots are tried under constant ready and under a periodic ready gap, which shows whether the output holds and the scan stalls. The same list is then run with per-channel gains, with timer pacing against fast and slow periods, in continuous mode cut short by a stop, with a silent converter and with writes issued mid-scan. Each of these runs checks one selection rule: gain source, tick source, overrun, wrap and stop, timeout, and write blocking.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_SETUP, S_SETTLE, S_CONV, S_DONE, S_OUT
  } seq_state_e;

  localparam logic [1:0] WSEL_LIST   = 2'd0;
  localparam logic [1:0] WSEL_SETTLE = 2'd1;
  localparam logic [1:0] WSEL_CHGAIN = 2'd2;
endpackage

// File: rtl/scan_cfg_store.sv
module scan_cfg_store
  import scan_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int CH_W     = 5,
  parameter int GAIN_W   = 3,
  parameter int SETTLE_W = 16,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int ENT_W   = CH_W + GAIN_W,
  localparam int NUM_CH  = 1 << CH_W,
  localparam int NUM_GN  = 1 << GAIN_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [IDX_W-1:0]    wr_addr,
  input  logic [SETTLE_W-1:0] wr_data,
  input  logic                locked,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic                gain_mode,
  output logic [CH_W-1:0]     ent_ch,
  output logic [GAIN_W-1:0]   ent_gain,
  output logic [SETTLE_W-1:0] ent_settle
);
  logic [ENT_W-1:0]    slot_q   [DEPTH];
  logic [SETTLE_W-1:0] settle_q [NUM_GN];
  logic [GAIN_W-1:0]   chg_q    [NUM_CH];

  logic wr_ok;
  assign wr_ok = wr_en && !locked;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[i] <= '0;
      else if (wr_ok && wr_sel == WSEL_LIST && wr_addr == IDX_W'(i))
        slot_q[i] <= wr_data[ENT_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GN; g++) begin : g_settle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        settle_q[g] <= '0;
      else if (wr_ok && wr_sel == WSEL_SETTLE && wr_addr[GAIN_W-1:0] == GAIN_W'(g))
        settle_q[g] <= wr_data;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        chg_q[c] <= '0;
      else if (wr_ok && wr_sel == WSEL_CHGAIN && wr_addr[CH_W-1:0] == CH_W'(c))
        chg_q[c] <= wr_data[GAIN_W-1:0];
    end
  end

  logic [ENT_W-1:0] cur;
  always_comb begin
    cur        = slot_q[rd_idx];
    ent_ch     = cur[CH_W-1:0];
    ent_gain   = gain_mode ? chg_q[ent_ch] : cur[ENT_W-1:CH_W];
    ent_settle = settle_q[ent_gain];
  end
endmodule

// File: rtl/scan_pacer.sv
module scan_pacer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               use_timer,
  input  logic [TIMER_W-1:0] period,
  input  logic               ext_trig,
  output logic               tick
);
  logic [TIMER_W-1:0] cnt_q;
  logic [TIMER_W:0]   cnt_nx;
  logic               hit;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign hit    = cnt_nx >= {1'b0, period};
  assign tick   = use_timer ? hit : ext_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || hit)
      cnt_q <= '0;
    else
      cnt_q <= cnt_nx[TIMER_W-1:0];
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int CH_W     = 5,
  parameter int GAIN_W   = 3,
  parameter int SETTLE_W = 16,
  parameter int DATA_W   = 16,
  parameter int TMO_CYC  = 64,
  localparam int TMO_W   = $clog2(TMO_CYC) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                stop_req,
  input  logic                cont_mode,
  input  logic                gain_mode,
  input  logic [IDX_W-1:0]    last_idx,
  input  logic                tick,
  input  logic [CH_W-1:0]     ent_ch,
  input  logic [GAIN_W-1:0]   ent_gain,
  input  logic [SETTLE_W-1:0] ent_settle,
  input  logic                conv_done,
  input  logic [DATA_W-1:0]   conv_data,
  input  logic                out_ready,
  output logic [IDX_W-1:0]    rd_idx,
  output logic                gmode,
  output logic                busy,
  output logic [CH_W-1:0]     mux_addr,
  output logic [GAIN_W-1:0]   pga_gain,
  output logic                conv_start,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic [CH_W-1:0]     out_chan,
  output logic [IDX_W-1:0]    out_index,
  output logic                scan_done,
  output logic                overrun,
  output logic                timeout_err
);
  seq_state_e st_q, st_nx;
  logic [IDX_W-1:0]    idx_q, last_q;
  logic                cont_q, gmode_q, stop_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic [TMO_W-1:0]    tmo_q;
  logic [CH_W-1:0]     mux_q;
  logic [GAIN_W-1:0]   gain_q;
  logic [DATA_W-1:0]   data_q;
  logic                done_q, ovr_q, err_q;

  logic start_ok, tmo_hit, advance, at_last, finish;
  seq_state_e adv_st;

  assign start_ok = start && (st_q == S_IDLE);
  assign tmo_hit  = (st_q == S_DONE) && !conv_done && (tmo_q == TMO_W'(TMO_CYC - 1));
  assign advance  = ((st_q == S_OUT) && out_ready) || tmo_hit;
  assign at_last  = (idx_q == last_q);
  assign finish   = at_last && !cont_q;
  assign adv_st   = (finish || stop_q) ? S_IDLE : S_WAIT;

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      S_IDLE:   if (start) st_nx = S_WAIT;
      S_WAIT:   if (stop_q) st_nx = S_IDLE;
                else if (tick) st_nx = S_SETUP;
      S_SETUP:  st_nx = (ent_settle == '0) ? S_CONV : S_SETTLE;
      S_SETTLE: if (cnt_q == SETTLE_W'(1)) st_nx = S_CONV;
      S_CONV:   st_nx = S_DONE;
      S_DONE:   if (conv_done) st_nx = S_OUT;
                else if (tmo_hit) st_nx = adv_st;
      S_OUT:    if (out_ready) st_nx = adv_st;
      default:  st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      cont_q  <= 1'b0;
      gmode_q <= 1'b0;
      stop_q  <= 1'b0;
      cnt_q   <= '0;
      tmo_q   <= '0;
      mux_q   <= '0;
      gain_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q <= st_nx;
      if (start_ok) begin
        idx_q   <= '0;
        last_q  <= last_idx;
        cont_q  <= cont_mode;
        gmode_q <= gain_mode;
        stop_q  <= 1'b0;
        done_q  <= 1'b0;
        ovr_q   <= 1'b0;
        err_q   <= 1'b0;
      end else begin
        if (stop_req) stop_q <= 1'b1;
        if (busy && st_q != S_WAIT && tick) ovr_q <= 1'b1;
      end
      case (st_q)
        S_SETUP: begin
          mux_q  <= ent_ch;
          gain_q <= ent_gain;
          cnt_q  <= ent_settle;
        end
        S_SETTLE: cnt_q <= cnt_q - 1'b1;
        S_CONV:   tmo_q <= '0;
        S_DONE: begin
          tmo_q <= tmo_q + 1'b1;
          if (conv_done) data_q <= conv_data;
        end
        default: ;
      endcase
      if (tmo_hit) err_q <= 1'b1;
      if (advance) begin
        idx_q <= at_last ? '0 : idx_q + 1'b1;
        if (finish) done_q <= 1'b1;
      end
    end
  end

  assign rd_idx      = idx_q;
  assign gmode       = gmode_q;
  assign busy        = (st_q != S_IDLE);
  assign mux_addr    = mux_q;
  assign pga_gain    = gain_q;
  assign conv_start  = (st_q == S_CONV);
  assign out_valid   = (st_q == S_OUT);
  assign out_data    = data_q;
  assign out_chan    = mux_q;
  assign out_index   = idx_q;
  assign scan_done   = done_q;
  assign overrun     = ovr_q;
  assign timeout_err = err_q;
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int CH_W     = 5,
  parameter int GAIN_W   = 3,
  parameter int SETTLE_W = 16,
  parameter int DATA_W   = 16,
  parameter int TIMER_W  = 16,
  parameter int TMO_CYC  = 64,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [IDX_W-1:0]    wr_addr,
  input  logic [SETTLE_W-1:0] wr_data,
  input  logic                start,
  input  logic                stop_req,
  input  logic                cont_mode,
  input  logic                gain_mode,
  input  logic [IDX_W-1:0]    last_idx,
  input  logic                use_timer,
  input  logic [TIMER_W-1:0]  timer_period,
  input  logic                ext_trig,
  output logic [CH_W-1:0]     mux_addr,
  output logic [GAIN_W-1:0]   pga_gain,
  output logic                conv_start,
  input  logic                conv_done,
  input  logic [DATA_W-1:0]   conv_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic [CH_W-1:0]     out_chan,
  output logic [IDX_W-1:0]    out_index,
  output logic                busy,
  output logic                scan_done,
  output logic                overrun,
  output logic                timeout_err
);
  logic [IDX_W-1:0]    rd_idx;
  logic                gmode, tick;
  logic [CH_W-1:0]     ent_ch;
  logic [GAIN_W-1:0]   ent_gain;
  logic [SETTLE_W-1:0] ent_settle;

  scan_cfg_store #(
    .DEPTH(DEPTH), .CH_W(CH_W), .GAIN_W(GAIN_W), .SETTLE_W(SETTLE_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .locked(busy),
    .rd_idx(rd_idx), .gain_mode(gmode),
    .ent_ch(ent_ch), .ent_gain(ent_gain), .ent_settle(ent_settle)
  );

  scan_pacer #(.TIMER_W(TIMER_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(busy), .use_timer(use_timer),
    .period(timer_period), .ext_trig(ext_trig), .tick(tick)
  );

  scan_ctrl #(
    .IDX_W(IDX_W), .CH_W(CH_W), .GAIN_W(GAIN_W), .SETTLE_W(SETTLE_W),
    .DATA_W(DATA_W), .TMO_CYC(TMO_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_req(stop_req),
    .cont_mode(cont_mode), .gain_mode(gain_mode), .last_idx(last_idx),
    .tick(tick), .ent_ch(ent_ch), .ent_gain(ent_gain), .ent_settle(ent_settle),
    .conv_done(conv_done), .conv_data(conv_data), .out_ready(out_ready),
    .rd_idx(rd_idx), .gmode(gmode), .busy(busy),
    .mux_addr(mux_addr), .pga_gain(pga_gain), .conv_start(conv_start),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan),
    .out_index(out_index), .scan_done(scan_done), .overrun(overrun),
    .timeout_err(timeout_err)
  );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int CH_W   = 5,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CH_W-1:0]   mux_addr,
  input logic              conv_start,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CH_W-1:0]   out_chan,
  input logic [IDX_W-1:0]  out_index,
  input logic              busy,
  input logic              scan_done,
  input logic              overrun,
  input logic              timeout_err
);
  AST_STRB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R4
  AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> $stable(mux_addr)); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan) && $stable(out_index)); // R7
  AST_TAG_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_chan == mux_addr); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !busy); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !conv_start && !out_valid); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !start |=> overrun); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err && !start |=> timeout_err); // R6
endmodule

bind scan_seq scan_seq_chk #(.CH_W(CH_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_scan_seq.sv
module sim_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, start = 0, stop_req = 0, cont_mode = 0, gain_mode = 0;
  logic use_timer = 0, ext_trig = 0, conv_done = 0, out_ready = 1;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_addr = 0, last_idx = 0;
  logic [15:0] wr_data = 0, timer_period = 0, conv_data = 0;
  logic [4:0] mux_addr, out_chan;
  logic [2:0] pga_gain;
  logic conv_start, out_valid, busy, scan_done, overrun, timeout_err;
  logic [15:0] out_data;
  logic [7:0] out_index;

  scan_seq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_list[256], m_settle[8], m_chg[32];
  int m_idx, m_last, m_mux, m_gain, m_data, m_tcnt;
  bit m_busy, m_done, m_ovr, m_err, m_stop, m_cont, m_gmode, m_conv, m_valid;
  bit s_tick, s_stop, in_wait;

  task automatic mstep();
    bit busy_pre, hit;
    @(posedge clk);
    busy_pre = m_busy;
    hit = (m_tcnt + 1) >= int'(timer_period);
    s_tick = use_timer ? hit : ext_trig;
    s_stop = m_stop;
    if (!busy_pre || hit) m_tcnt = 0; else m_tcnt++;
    if (busy_pre && !in_wait && s_tick) m_ovr = 1;
    if (stop_req) m_stop = 1;
    if (wr_en && !busy_pre) begin
      case (wr_sel)
        2'd0: m_list[wr_addr] = int'(wr_data[7:0]);
        2'd1: m_settle[wr_addr[2:0]] = int'(wr_data);
        2'd2: m_chg[wr_addr[4:0]] = int'(wr_data[2:0]);
        default: ;
      endcase
    end
  endtask

  task automatic run_model();
    bit go, got;
    while (m_busy) begin
      go = 0;
      while (!go && m_busy) begin
        in_wait = 1; mstep();
        if (s_stop) m_busy = 0;
        else if (s_tick) go = 1;
      end
      in_wait = 0;
      if (!m_busy) break;
      mstep();
      m_mux  = m_list[m_idx] % 32;
      m_gain = m_gmode ? m_chg[m_mux] : (m_list[m_idx] / 32) % 8;
      repeat (m_settle[m_gain]) mstep();
      m_conv = 1;
      mstep();
      m_conv = 0;
      got = 0;
      for (int k = 0; ; k++) begin
        mstep();
        if (conv_done) begin m_data = int'(conv_data); m_valid = 1; got = 1; break; end
        if (k == TMO - 1) begin m_err = 1; break; end
      end
      if (got) begin
        do mstep(); while (!out_ready);
        m_valid = 0;
      end
      if (m_idx == m_last && !m_cont) begin m_done = 1; m_busy = 0; end
      else if (s_stop) m_busy = 0;
      m_idx = (m_idx == m_last) ? 0 : m_idx + 1;
    end
  endtask

  initial begin : model
    @(posedge rst_n);
    forever begin
      in_wait = 0;
      mstep();
      if (start) begin
        m_busy = 1; m_done = 0; m_ovr = 0; m_err = 0; m_stop = 0; m_idx = 0;
        m_last = int'(last_idx); m_cont = cont_mode; m_gmode = gain_mode;
        run_model();
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (!finished) begin
    chk("R1 mux_addr", mux_addr, m_mux);
    chk("R2 pga_gain", pga_gain, m_gain);
    chk("R3 conv_start", conv_start, m_conv);
    chk("R7 out_valid", out_valid, m_valid);
    chk("R8 busy", busy, m_busy);
    chk("R8 scan_done", scan_done, m_done);
    chk("R11 overrun", overrun, m_ovr);
    chk("R6 timeout_err", timeout_err, m_err);
    if (m_valid) begin
      chk("R5 out_data", out_data, m_data);
      chk("R5 out_chan", out_chan, m_mux);
      chk("R5 out_index", out_index, m_idx);
    end
  end

  // ---------------- environment: trigger, ready, converter ----------------
  int trig_per = 0, tcount = 0, cyc = 0, cv_cnt = 0, cv_lat = 2, data_ctr = 16'h0100;
  bit ready_gap = 0, cv_mute = 0;

  always @(negedge clk) begin
    cyc++;
    ext_trig = 0;
    if (trig_per > 0) begin
      tcount++;
      if (tcount >= trig_per) begin tcount = 0; ext_trig = 1; end
    end
    out_ready = ready_gap ? (cyc % 4 == 3) : 1'b1;
    conv_done = 0;
    if (cv_cnt > 0) begin
      cv_cnt--;
      if (cv_cnt == 0) begin
        conv_done = 1; conv_data = 16'(data_ctr); data_ctr += 37;
      end
    end
    if (conv_start && !cv_mute) cv_cnt = cv_lat;
  end

  task automatic wr(input logic [1:0] sel, input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_addr = 8'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic go_scan(input int last, input bit cont, input bit gm);
    @(negedge clk);
    last_idx = 8'(last); cont_mode = cont; gain_mode = gm; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired (R8 scan never ended)");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13 busy", busy, 0); chk("R13 out_valid", out_valid, 0);
    chk("R13 conv_start", conv_start, 0); chk("R13 mux_addr", mux_addr, 0);
    rst_n = 1;
    @(negedge clk);
    // settling counts: gain0=0, gain1=1, gain2=5, gain3=2, gain7=9 (R3)
    wr(2'd1, 0, 0); wr(2'd1, 1, 1); wr(2'd1, 2, 5); wr(2'd1, 3, 2); wr(2'd1, 7, 9);
    // slots: gain<<5 | channel (R1)
    wr(2'd0, 0, (0 << 5) | 3);  wr(2'd0, 1, (2 << 5) | 17);
    wr(2'd0, 2, (1 << 5) | 31); wr(2'd0, 3, (3 << 5) | 0);
    wr(2'd0, 4, (7 << 5) | 9);
    // per-channel gains (R2)
    wr(2'd2, 3, 7); wr(2'd2, 17, 1); wr(2'd2, 31, 0); wr(2'd2, 0, 2); wr(2'd2, 9, 3);

    // R1 R3 R4 R5 R8 R10: single scan, external trigger, no back-pressure
    trig_per = 40; cv_lat = 2;
    go_scan(4, 0, 0); wait_idle();
    chk("R8 done after single scan", scan_done, 1);

    // R7: back-pressure with a periodic ready gap
    ready_gap = 1; cv_lat = 1;
    go_scan(4, 0, 0); wait_idle();
    ready_gap = 0;

    // R2: per-channel gain mode
    go_scan(4, 0, 1); wait_idle();

    // R9: continuous wrap then stop
    cv_lat = 3;
    go_scan(2, 1, 0);
    repeat (300) @(negedge clk);
    stop_req = 1; @(negedge clk); stop_req = 0;
    wait_idle();
    chk("R9 idle after stop", busy, 0);
    chk("R9 no done in continuous", scan_done, 0);

    // R10: timer pacing, slow period
    trig_per = 0; use_timer = 1; timer_period = 30;
    go_scan(3, 0, 0); wait_idle();
    chk("R10 no overrun with slow timer", overrun, 0);
    // R11: fast timer causes overrun
    timer_period = 4;
    go_scan(3, 0, 0); wait_idle();
    chk("R11 overrun with fast timer", overrun, 1);
    // R11: fast external trigger
    use_timer = 0; trig_per = 3;
    go_scan(1, 0, 0); wait_idle();
    trig_per = 40;

    // R6: converter never answers
    cv_mute = 1;
    go_scan(1, 0, 0); wait_idle();
    chk("R6 timeout flagged", timeout_err, 1);
    cv_mute = 0;

    // R12: writes during a scan are ignored; rescan shows old contents
    go_scan(4, 0, 0);
    repeat (5) @(negedge clk);
    wr(2'd0, 0, (7 << 5) | 12); wr(2'd1, 0, 20); wr(2'd2, 3, 5);
    wait_idle();
    go_scan(0, 0, 0); wait_idle();
    go_scan(0, 0, 1); wait_idle();
    chk("R12 slot0 channel unchanged", mux_addr, 3);
    chk("R12 channel gain unchanged", pga_gain, 7);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule